// File: doc/BRIEF.md
# Two-Entry Receive Holding Buffer

This block holds received characters between the shift logic of a serial receiver and the host. It has two places for a character. One is the data register, which the host can see. The other is a hidden buffer register behind it. An internal pointer chooses where the next received character lands. The shift logic pulses a write strobe with a byte. The host pulses a read strobe to take the byte that is currently shown on the data output.

The pointer selects the data register while nothing is unread. It selects the buffer register once the data register holds an unread byte. A host read pops the oldest byte. If a second byte is waiting, that byte moves forward into the data register.

When a third byte arrives while both entries are full, the oldest byte is dropped. The buffer moves forward and the new byte takes its place. A sticky overrun flag records the loss until a clear strobe is given. If a read and a receive come in the same cycle, the read is handled first, and the new byte is then placed where the updated pointer points.

Top module: `rx_hold_buffer`

## Requirements
- R1: After reset both entries are empty. `rx_complete` and `overrun` are 0, and `rd_data` is 0.
- R2: A receive (`rx_wr`=1) into an empty block stores `rx_byte` in the data register. From the next cycle `rd_data` shows that byte and `rx_complete` is 1.
- R3: A read (`host_rd`=1) while only the data register is occupied clears `rx_complete` in the next cycle. `rd_data` keeps the byte that was just read.
- R4: A receive while exactly one byte is unread goes to the buffer register. `rd_data` still shows the older byte and `rx_complete` stays 1.
- R5: A read while both entries are full moves the newer byte into the data register, and `rx_complete` stays 1. The following read empties the block.
- R6: A receive while both entries are full drops the oldest byte. `rd_data` then shows the former buffer byte, the new byte waits behind it, and `overrun` becomes 1.
- R7: `overrun` stays 1 until a cycle with `ovf_clr`=1 clears it. If a drop and `ovf_clr` happen in the same cycle, `overrun` is set.
- R8: A read and a receive in the same cycle act as the read followed by the receive. With one byte unread, the new byte becomes the data register byte. With two unread, the newer byte moves forward, the new byte goes to the buffer, and nothing is dropped.
- R9: A read while nothing is unread changes nothing: `rd_data`, `rx_complete` and `overrun` all hold their values.
- R10: While `en`=0 both entries are marked empty, so `rx_complete` is 0 and the pointer returns to the data register. Receive and read strobes are ignored. `rd_data` keeps its last value, and `ovf_clr` still clears `overrun`.
- R11: `rx_complete` is 1 exactly when at least one received byte has not yet been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Block enable; low empties both entries |
| rx_wr | input | 1 | Receive strobe from the shift logic |
| rx_byte | input | DATA_W | Received character |
| host_rd | input | 1 | Host read strobe; pops the shown byte |
| ovf_clr | input | 1 | Clears the overrun flag |
| rd_data | output | DATA_W | Contents of the data register |
| rx_complete | output | 1 | Unread data present in the data register |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
The assertions assume that every strobe is a clean one-cycle-or-longer level, sampled once per clock. They also assume that `rx_byte` is valid in any cycle where `rx_wr` is high, and that the host reads only the value shown on `rd_data` in the cycle of its strobe. The stimulus drives all inputs as whole-cycle levels set away from the clock edge and never leaves `rx_byte` unknown. It walks each fill level with every combination of read, receive and clear, and then runs a pseudo-random mix that includes disabled stretches.

// File: rtl/rx_hold_pkg.sv
// Shared types for the two-entry receive holding buffer.
package rx_hold_pkg;

    // Where the next received character lands.
    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_BUF  = 1'b1
    } rxh_ptr_e;

    // Register load controls decided by the pointer logic each cycle.
    typedef struct packed {
        logic ld_data_in;   // data register takes the incoming byte
        logic ld_data_buf;  // data register takes the buffer byte
        logic ld_buf_in;    // buffer register takes the incoming byte
        logic drop;         // the oldest byte is discarded this cycle
    } rxh_ctl_t;

endpackage

// File: rtl/rx_hold_ctrl.sv
// Pointer and occupancy control for the receive holding buffer.
// Handles a read first and then a receive, in the same cycle.
// Assumes that strobes are synchronous to clk. Reset is synchronous and active low.
module rx_hold_ctrl
    import rx_hold_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     rx_wr,
    input  logic     host_rd,
    output rxh_ctl_t ctl,
    output logic [1:0] fill
);

    rxh_ptr_e ptr_q, ptr_d;
    logic     full_q, full_d;
    rxh_ptr_e ptr_mid;
    logic     full_mid;
    logic     rd_eff;

    // Decide the loads and next pointer: read step first, then receive step.
    always_comb begin
        ctl      = '0;
        rd_eff   = en && host_rd && (ptr_q == SEL_BUF);
        ptr_mid  = ptr_q;
        full_mid = full_q;
        if (rd_eff) begin
            if (full_q) begin
                ctl.ld_data_buf = 1'b1;
                full_mid        = 1'b0;
            end else begin
                ptr_mid = SEL_DATA;
            end
        end
        ptr_d  = ptr_mid;
        full_d = full_mid;
        if (en && rx_wr) begin
            if (ptr_mid == SEL_DATA) begin
                ctl.ld_data_in = 1'b1;
                ptr_d          = SEL_BUF;
                full_d         = 1'b0;
            end else if (!full_mid) begin
                ctl.ld_buf_in = 1'b1;
                full_d        = 1'b1;
            end else begin
                ctl.ld_data_buf = 1'b1;
                ctl.ld_buf_in   = 1'b1;
                ctl.drop        = 1'b1;
                full_d          = 1'b1;
            end
        end
        if (!en) begin
            ptr_d  = SEL_DATA;
            full_d = 1'b0;
        end
    end

    // Hold pointer and buffer-occupied state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= SEL_DATA;
            full_q <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            full_q <= full_d;
        end
    end

    // Encode the number of unread bytes (0, 1 or 2).
    always_comb begin
        if (ptr_q == SEL_DATA) fill = 2'd0;
        else if (!full_q)      fill = 2'd1;
        else                   fill = 2'd2;
    end

endmodule

// File: rtl/rx_hold_regs.sv
// Storage for the visible data register and the hidden buffer register.
// Assumes that at most one data-register source is selected per cycle.
module rx_hold_regs
    import rx_hold_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rxh_ctl_t          ctl,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] buf_q
);

    // Load the data register from the input or from the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)              data_q <= '0;
        else if (ctl.ld_data_in)  data_q <= din;
        else if (ctl.ld_data_buf) data_q <= buf_q;
    end

    // Load the buffer register from the input.
    always_ff @(posedge clk) begin
        if (!rst_n)             buf_q <= '0;
        else if (ctl.ld_buf_in) buf_q <= din;
    end

endmodule

// File: rtl/rx_hold_ovf.sv
// Sticky overrun flag. A set wins over a clear in the same cycle.
module rx_hold_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_q
);

    // Set on a drop; clear on a clear strobe without a drop.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

endmodule

// File: rtl/rx_hold_buffer.sv
// Two-entry receive holding buffer: a visible data register and a hidden
// buffer register, steered by a pointer, with drop-oldest overrun handling.
// Assumes that rx_byte is valid whenever rx_wr is high.
module rx_hold_buffer
    import rx_hold_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rx_wr,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              host_rd,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_complete,
    output logic              overrun
);

    rxh_ctl_t          ctl;
    logic [1:0]        fill;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] buf_q;

    rx_hold_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .rx_wr   (rx_wr),
        .host_rd (host_rd),
        .ctl     (ctl),
        .fill    (fill)
    );

    rx_hold_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (ctl),
        .din    (rx_byte),
        .data_q (data_q),
        .buf_q  (buf_q)
    );

    rx_hold_ovf u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ctl.drop),
        .clr_i  (ovf_clr),
        .flag_q (overrun)
    );

    // Drive the outputs from the stored state.
    always_comb begin
        rd_data     = data_q;
        rx_complete = (fill != 2'd0);
    end

endmodule

// File: rtl/rx_hold_buffer_chk.sv
// Property checker for rx_hold_buffer. It is bound to the top module.
module rx_hold_buffer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              rx_wr,
    input logic [DATA_W-1:0] rx_byte,
    input logic              host_rd,
    input logic              ovf_clr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_complete,
    input logic              overrun,
    input logic [1:0]        fill
);

    // R2: a receive into an empty block is shown next cycle
    a_r2_first_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_wr && fill == 2'd0) |=> (rx_complete && rd_data == $past(rx_byte)));

    // R3: a read of a single entry empties the block and keeps the shown byte
    a_r3_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (en && host_rd && !rx_wr && fill == 2'd1) |=> (!rx_complete && $stable(rd_data)));

    // R4: a second receive leaves the shown byte alone
    a_r4_second_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_wr && !host_rd && fill == 2'd1) |=> (rx_complete && $stable(rd_data) && fill == 2'd2));

    // R6: a receive into a full block raises overrun
    a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_wr && !host_rd && fill == 2'd2) |=> overrun);

    // R7: overrun is sticky without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovf_clr) |=> overrun);

    // R8: a read together with a receive on a full block drops nothing
    a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_wr && host_rd && fill == 2'd2 && !overrun && !ovf_clr) |=> (!overrun && fill == 2'd2));

    // R9: a read with nothing unread changes nothing
    a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (en && host_rd && !rx_wr && fill == 2'd0 && !ovf_clr) |=> ($stable(rd_data) && !rx_complete && $stable(overrun)));

    // R10: a disabled block empties and holds its data register
    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (!rx_complete && $stable(rd_data)));

endmodule

bind rx_hold_buffer rx_hold_buffer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .rx_wr       (rx_wr),
    .rx_byte     (rx_byte),
    .host_rd     (host_rd),
    .ovf_clr     (ovf_clr),
    .rd_data     (rd_data),
    .rx_complete (rx_complete),
    .overrun     (overrun),
    .fill        (fill)
);

// File: tb/tb_rx_hold_buffer.sv
// Bench for rx_hold_buffer. A queue-based model is compared on every clock.
module tb_rx_hold_buffer;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b1;
    logic         rx_wr = 1'b0;
    logic [W-1:0] rx_byte = '0;
    logic         host_rd = 1'b0;
    logic         ovf_clr = 1'b0;
    logic [W-1:0] rd_data;
    logic         rx_complete;
    logic         overrun;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] mq[$];
    logic [W-1:0] m_data = '0;
    logic         m_ovf = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_hold_buffer #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_wr(rx_wr), .rx_byte(rx_byte),
        .host_rd(host_rd), .ovf_clr(ovf_clr), .rd_data(rd_data),
        .rx_complete(rx_complete), .overrun(overrun)
    );

    task automatic check(input string tag, input logic [W-1:0] exp_d,
                         input logic exp_c, input logic exp_o);
        checks++;
        if (rd_data !== exp_d || rx_complete !== exp_c || overrun !== exp_o) begin
            errors++;
            $display("FAIL %s: got data=%h rxc=%b ovr=%b, expected data=%h rxc=%b ovr=%b",
                     tag, rd_data, rx_complete, overrun, exp_d, exp_c, exp_o);
        end
    endtask

    // Apply one cycle of inputs, advance the model, and compare after the edge.
    task automatic step(input logic w, input logic [W-1:0] b, input logic r,
                        input logic c, input logic e, input string tag);
        logic set;
        en = e; rx_wr = w; rx_byte = b; host_rd = r; ovf_clr = c;
        @(posedge clk);
        set = 1'b0;
        if (!e) begin
            mq.delete();
        end else begin
            if (r && mq.size() > 0) void'(mq.pop_front());
            if (w) begin
                if (mq.size() == 2) begin
                    void'(mq.pop_front());
                    set = 1'b1;
                end
                mq.push_back(b);
            end
        end
        if (mq.size() > 0) m_data = mq[0];
        if (set)    m_ovf = 1'b1;
        else if (c) m_ovf = 1'b0;
        #2;
        check(tag, m_data, mq.size() > 0, m_ovf);
        rx_wr = 1'b0; host_rd = 1'b0; ovf_clr = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset state", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(0, 8'h00, 0, 0, 1, "R1 idle after reset");
        step(0, 8'h00, 1, 0, 1, "R9 read when empty");
        step(1, 8'hA1, 0, 0, 1, "R2 first receive");
        step(0, 8'h00, 1, 0, 1, "R3 single read");
        step(0, 8'h00, 1, 0, 1, "R9 read after drain");
        step(1, 8'hB2, 0, 0, 1, "R2 receive");
        step(1, 8'hC3, 0, 0, 1, "R4 second receive");
        step(0, 8'h00, 1, 0, 1, "R5 read with two");
        step(0, 8'h00, 1, 0, 1, "R5 second read");
        step(1, 8'hD4, 0, 0, 1, "R2 receive");
        step(1, 8'hE5, 0, 0, 1, "R4 receive");
        step(1, 8'hF6, 0, 0, 1, "R6 drop oldest");
        step(0, 8'h00, 0, 0, 1, "R7 overrun holds");
        step(0, 8'h00, 1, 0, 1, "R6 shown after drop");
        step(0, 8'h00, 1, 1, 1, "R7 clear");
        step(1, 8'h11, 0, 0, 1, "R11 one unread");
        step(1, 8'h22, 1, 0, 1, "R8 read+receive at one");
        step(1, 8'h33, 0, 0, 1, "R4 receive");
        step(1, 8'h44, 1, 0, 1, "R8 read+receive at two");
        step(1, 8'h55, 0, 1, 1, "R7 set wins over clear");
        step(0, 8'h00, 0, 1, 0, "R10 disable empties, clear works");
        step(1, 8'h66, 1, 0, 0, "R10 strobes ignored");
        step(0, 8'h00, 1, 0, 1, "R10 re-enabled empty");
        step(1, 8'h77, 0, 0, 1, "R10 pointer on data register");
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[15:8], lfsr[1], lfsr[2] & lfsr[3],
                 (lfsr[6:4] != 3'd0), "R11 random mix");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule